// File: doc/BRIEF.md
# Power-Management Wake and Interrupt Collector

This block gathers every source that may raise the power-management interrupt. It holds two wake-up recognizers. Each one watches a 32-bit vector of system events through its own select mask and reports a request when a selected event line rises. The three standby timers, which sit outside this block, supply one request pulse each.

A five-bit enable register and a matching request status register sit behind a small register port. When a source fires while its enable bit is set, its status bit latches. The active-low interrupt output stays asserted while any status bit is held. The interrupt handler reads the status register to find the cause and writes ones back to clear the bits it has serviced.

Wake recognition has no input from the system power state, so a wake event is seen in sleep and in throttling alike. Wake set 1 has a fixed group of event lines it cannot select.

Top module: `pm_irq_collect`

## Requirements
- R1: After reset, all four registers read zero and `smi_n_o` is high.
- R2: Register map on `reg_addr`: 0 is the wake set 0 select mask, 1 is the wake set 1 select mask, 2 is the enable register, 3 is the status register. Reads are combinational from `reg_addr`. Writes take effect at the clock edge where `reg_wr` is high.
- R3: A request on `tmr_req_i[0]`, `[1]` or `[2]` sets status bit 31, 30 or 29 respectively at the next clock edge when the matching enable bit is set. `smi_n_o` is then low.
- R4: A source that fires while its enable bit is clear leaves the status register unchanged and `smi_n_o` high.
- R5: Wake set 0 sets status bit 28 and wake set 1 sets status bit 27, each with enable bit 28 or 27. A set fires once per rising edge of an event line selected in its mask. An event line held high raises only one request.
- R6: A rising edge on an event line not selected in a set's mask raises no request from that set.
- R7: With the default lock parameter, event lines 7 to 4 cannot be selected by wake set 1. Those mask bits read zero and ignore writes. Wake set 0 can select all 32 lines.
- R8: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. A source firing in the same cycle as the clearing write leaves the bit set.
- R9: `smi_n_o` is low exactly while some status bit is set. It rises at the edge that clears the last set bit, and stays low while any other bit remains set.
- R10: Enable and status bits other than 31 to 27 read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| events_i | input | 32 | Raw system event lines |
| tmr_req_i | input | 3 | Request pulses from standby timers 0..2 |
| smi_n_o | output | 1 | Active-low power-management interrupt |

## Verification
Every result appears at the first clock edge after its cause. A timer pulse, a rising event edge or a register write in one cycle changes the status bits and `smi_n_o` at that cycle's closing edge. Read data then follows combinationally.

The bench drives its stimulus on falling edges. Each expected value is queued in a read cycle that holds all inputs quiet, so no state can change in that cycle. The monitor compares the queued value five nanoseconds after the following rising edge.

// File: rtl/pm_irq_pkg.sv
`timescale 1ns/1ps
package pm_irq_pkg;
  localparam int DW        = 32;
  localparam int TMR_N     = 3;
  localparam int TMR_HI    = 31;
  localparam int WAKE_N    = 2;
  localparam int WAKE0_POS = 28;

  typedef enum logic [1:0] {
    RA_WMASK0 = 2'd0,
    RA_WMASK1 = 2'd1,
    RA_ENABLE = 2'd2,
    RA_STATUS = 2'd3
  } reg_addr_e;

  // bits of enable/status that exist
  function automatic logic [DW-1:0] f_impl_mask();
    logic [DW-1:0] m;
    m = '0;
    for (int i = 0; i < TMR_N; i++) m[TMR_HI-i] = 1'b1;
    for (int j = 0; j < WAKE_N; j++) m[WAKE0_POS-j] = 1'b1;
    return m;
  endfunction

  // place timer and wake requests at their status positions
  function automatic logic [DW-1:0] f_src_vec(input logic [TMR_N-1:0] tmr,
                                               input logic [WAKE_N-1:0] wake);
    logic [DW-1:0] v;
    v = '0;
    for (int i = 0; i < TMR_N; i++) v[TMR_HI-i] = tmr[i];
    for (int j = 0; j < WAKE_N; j++) v[WAKE0_POS-j] = wake[j];
    return v;
  endfunction

  // new sets win over write-1 clears
  function automatic logic [DW-1:0] f_stat_next(input logic [DW-1:0] stat,
                                                 input logic [DW-1:0] src,
                                                 input logic [DW-1:0] en,
                                                 input logic [DW-1:0] clr);
    return ((stat & ~clr) | (src & en)) & f_impl_mask();
  endfunction
endpackage

// File: rtl/pm_wake_detect.sv
`timescale 1ns/1ps
module pm_wake_detect
  import pm_irq_pkg::*;
#(
  parameter logic [DW-1:0] SEL_LOCK = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_we,
  input  logic [DW-1:0] sel_wdata,
  input  logic [DW-1:0] events_i,
  output logic [DW-1:0] sel_q,
  output logic          hit_o
);
  localparam logic [DW-1:0] SEL_OPEN = ~SEL_LOCK;

  logic [DW-1:0] ev_prev;
  logic [DW-1:0] ev_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q   <= '0;
      ev_prev <= '0;
    end else begin
      ev_prev <= events_i;
      if (sel_we) sel_q <= sel_wdata & SEL_OPEN;
    end
  end

  // edge detect, independent of any power state
  assign ev_rise = events_i & ~ev_prev;
  assign hit_o   = |(ev_rise & sel_q);
endmodule

// File: rtl/pm_irq_status.sv
`timescale 1ns/1ps
module pm_irq_status
  import pm_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_we,
  input  logic          clr_we,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] src,
  output logic [DW-1:0] en_q,
  output logic [DW-1:0] stat_q
);
  localparam logic [DW-1:0] IMPL = f_impl_mask();

  logic [DW-1:0] clr_vec;
  assign clr_vec = clr_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      stat_q <= '0;
    end else begin
      if (en_we) en_q <= wdata & IMPL;
      stat_q <= f_stat_next(stat_q, src, en_q, clr_vec);
    end
  end
endmodule

// File: rtl/pm_irq_collect.sv
`timescale 1ns/1ps
module pm_irq_collect
  import pm_irq_pkg::*;
#(
  parameter logic [DW-1:0] W1_LOCK = 32'h0000_00F0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic [DW-1:0]    events_i,
  input  logic [TMR_N-1:0] tmr_req_i,
  output logic             smi_n_o
);
  reg_addr_e      ra;
  logic [DW-1:0]  sel_q [WAKE_N];
  logic [WAKE_N-1:0] wake_hit;
  logic [DW-1:0]  src_vec;
  logic [DW-1:0]  en_q;
  logic [DW-1:0]  stat_q;
  logic           en_we;
  logic           stat_clr_we;

  assign ra          = reg_addr_e'(reg_addr);
  assign en_we       = reg_wr && (ra == RA_ENABLE);
  assign stat_clr_we = reg_wr && (ra == RA_STATUS);

  for (genvar g = 0; g < WAKE_N; g++) begin : g_wake
    localparam reg_addr_e MY_RA = (g == 0) ? RA_WMASK0 : RA_WMASK1;
    localparam logic [DW-1:0] LOCK = (g == 1) ? W1_LOCK : '0;
    pm_wake_detect #(.SEL_LOCK(LOCK)) u_det (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_we   (reg_wr && (ra == MY_RA)),
      .sel_wdata(reg_wdata),
      .events_i (events_i),
      .sel_q    (sel_q[g]),
      .hit_o    (wake_hit[g])
    );
  end

  assign src_vec = f_src_vec(tmr_req_i, wake_hit);

  pm_irq_status u_stat (
    .clk   (clk),
    .rst_n (rst_n),
    .en_we (en_we),
    .clr_we(stat_clr_we),
    .wdata (reg_wdata),
    .src   (src_vec),
    .en_q  (en_q),
    .stat_q(stat_q)
  );

  always_comb begin
    unique case (ra)
      RA_WMASK0: reg_rdata = sel_q[0];
      RA_WMASK1: reg_rdata = sel_q[1];
      RA_ENABLE: reg_rdata = en_q;
      default:   reg_rdata = stat_q;
    endcase
  end

  assign smi_n_o = ~|stat_q;
endmodule

// File: rtl/pm_irq_collect_chk.sv
`timescale 1ns/1ps
module pm_irq_collect_chk
  import pm_irq_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] src,
  input logic [DW-1:0] en,
  input logic [DW-1:0] stat,
  input logic          clr_we,
  input logic [DW-1:0] wdata,
  input logic          smi_n
);
  localparam logic [DW-1:0] IMPL = f_impl_mask();

  // R3 / R5: an enabled source brings the interrupt low next cycle
  a_r3_enabled_src_fires: assert property (@(posedge clk) disable iff (!rst_n)
    ((src & en) != '0) |=> !smi_n);

  // R4: no status bit appears without an enabled source
  a_r4_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (stat & ~$past(stat) & ~($past(src) & $past(en))) == '0);

  // R8: a clearing write with no competing set empties those bits
  a_r8_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && ((src & en & wdata) == '0)) |=> ((stat & $past(wdata)) == '0));

  // R9: emptying the status register releases the interrupt
  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(stat) != '0) && (stat == '0)) |-> $rose(smi_n));

  // R10: unimplemented bits never hold a one
  a_r10_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat | en) & ~IMPL) == '0);
endmodule

bind pm_irq_collect pm_irq_collect_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .src   (src_vec),
  .en    (en_q),
  .stat  (stat_q),
  .clr_we(stat_clr_we),
  .wdata (reg_wdata),
  .smi_n (smi_n_o)
);

// File: tb/test_pm_irq_collect.sv
`timescale 1ns/1ps
module test_pm_irq_collect;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] events_i = '0;
  logic [2:0]  tmr_req_i = '0;
  logic        smi_n_o;

  int n_total = 0;
  int n_bad   = 0;
  bit done    = 1'b0;
  logic [31:0] cur_ev = '0;

  typedef struct {
    logic [1:0]  a;
    logic [31:0] d;
    logic        smi;
    string       tag;
  } exp_t;
  exp_t q[$];

  pm_irq_collect i_pm_irq_collect (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .events_i(events_i),
    .tmr_req_i(tmr_req_i), .smi_n_o(smi_n_o)
  );

  always #10 clk = ~clk;

  task automatic cyc(input bit wr, input logic [1:0] a,
                     input logic [31:0] d, input logic [2:0] tm);
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = d; tmr_req_i = tm; events_i = cur_ev;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, 3'b000);
  endtask

  task automatic ev_set(input logic [31:0] v);
    cur_ev = v;
    cyc(1'b0, 2'd0, '0, 3'b000);
  endtask

  // quiet read cycle; expected item goes to the scoreboard
  task automatic chk(input logic [1:0] a, input logic [31:0] d,
                     input logic smi, input string tag);
    exp_t e;
    cyc(1'b0, a, '0, 3'b000);
    e.a = a; e.d = d; e.smi = smi; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_total++;
        if (reg_rdata !== e.d || smi_n_o !== e.smi) begin
          n_bad++;
          $display("FAIL %s: addr=%0d rdata=%h smi_n=%b expected rdata=%h smi_n=%b",
                   e.tag, e.a, reg_rdata, smi_n_o, e.d, e.smi);
        end
      end
    end
  end

  // watchdog
  initial begin
    #(20 * 100000);
    if (!done) begin
      n_total++; n_bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(2'd0, 32'h0, 1'b1, "R1 mask0");
    chk(2'd1, 32'h0, 1'b1, "R1 mask1");
    chk(2'd2, 32'h0, 1'b1, "R1 enable");
    chk(2'd3, 32'h0, 1'b1, "R1 status");
    // R10 unused bits
    wr(2'd2, 32'hFFFF_FFFF);
    chk(2'd2, 32'hF800_0000, 1'b1, "R10 enable");
    wr(2'd3, 32'hFFFF_FFFF);
    chk(2'd3, 32'h0, 1'b1, "R10 status");
    // R4 disabled timers
    wr(2'd2, 32'h0);
    cyc(1'b0, 2'd0, '0, 3'b111);
    chk(2'd3, 32'h0, 1'b1, "R4 timers disabled");
    // R3 timer mapping
    wr(2'd2, 32'hF800_0000);
    cyc(1'b0, 2'd0, '0, 3'b001);
    chk(2'd3, 32'h8000_0000, 1'b0, "R3 timer0");
    cyc(1'b0, 2'd0, '0, 3'b100);
    chk(2'd3, 32'hA000_0000, 1'b0, "R3 timer2");
    // R8 write-1 clear
    wr(2'd3, 32'h2000_0000);
    chk(2'd3, 32'h8000_0000, 1'b0, "R8 clear one");
    wr(2'd3, 32'h0);
    chk(2'd3, 32'h8000_0000, 1'b0, "R8 zero write");
    cyc(1'b1, 2'd3, 32'h8000_0000, 3'b001);
    chk(2'd3, 32'h8000_0000, 1'b0, "R8 set beats clear");
    // R9 interrupt follows last bit
    cyc(1'b0, 2'd0, '0, 3'b010);
    chk(2'd3, 32'hC000_0000, 1'b0, "R3 timer1");
    wr(2'd3, 32'h8000_0000);
    chk(2'd3, 32'h4000_0000, 1'b0, "R9 one left");
    wr(2'd3, 32'h4000_0000);
    chk(2'd3, 32'h0, 1'b1, "R9 released");
    // R7 / R2 mask access
    wr(2'd1, 32'hFFFF_FFFF);
    chk(2'd1, 32'hFFFF_FF0F, 1'b1, "R7 mask1 lock");
    wr(2'd0, 32'hFFFF_FFFF);
    chk(2'd0, 32'hFFFF_FFFF, 1'b1, "R2 mask0");
    // R5 wake sets, edge based
    wr(2'd0, 32'h0000_0001);
    wr(2'd1, 32'h0000_0002);
    ev_set(32'h1);
    chk(2'd3, 32'h1000_0000, 1'b0, "R5 wake0");
    wr(2'd3, 32'h1000_0000);
    chk(2'd3, 32'h0, 1'b1, "R5 held level once");
    chk(2'd3, 32'h0, 1'b1, "R5 held level stays");
    ev_set(32'h3);
    chk(2'd3, 32'h0800_0000, 1'b0, "R5 wake1");
    wr(2'd3, 32'h0800_0000);
    ev_set(32'h0);
    // R6 unselected line
    ev_set(32'h4);
    chk(2'd3, 32'h0, 1'b1, "R6 unselected");
    ev_set(32'h0);
    // R7 locked line in set 1
    wr(2'd1, 32'h0000_0010);
    chk(2'd1, 32'h0, 1'b1, "R7 lock write");
    ev_set(32'h10);
    chk(2'd3, 32'h0, 1'b1, "R7 set1 blind");
    ev_set(32'h0);
    wr(2'd0, 32'h0000_0010);
    ev_set(32'h10);
    chk(2'd3, 32'h1000_0000, 1'b0, "R7 set0 sees line");
    // R4 wake disabled
    wr(2'd3, 32'h1000_0000);
    wr(2'd2, 32'h0);
    ev_set(32'h0);
    ev_set(32'h10);
    chk(2'd3, 32'h0, 1'b1, "R4 wake disabled");
    // drain
    cyc(1'b0, 2'd0, '0, 3'b000);
    cyc(1'b0, 2'd0, '0, 3'b000);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end
endmodule